// File: doc/BRIEF.md
# Modular Butterfly Unit over a Small Prime Field

This block computes one butterfly step of a number-theoretic transform over the integers modulo a small prime `Q`, which defaults to 17. It takes two residues `a` and `b` and a twiddle residue `w`. It forms the product `p = b·w mod Q` once. From that single product it derives `u = (a + p) mod Q` and `v = (a − p) mod Q`.

The multiplier takes the full integer product and reduces it modulo `Q`. The adder subtracts `Q` at most once, when the raw sum reaches `Q`. The subtractor adds `Q` at most once, when the raw difference goes negative. The two results are captured in an output register, which loads only on cycles where the input-valid strobe is high. An output-valid strobe follows the input strobe one cycle later. A sequencer that walks the transform stages can therefore issue one butterfly per cycle and collect the results one cycle later.

Top module: `zq_butterfly`

## Requirements
- R1: One cycle after a cycle with `in_vld` high, `u_out` equals `(a_in + b_in·w_in) mod Q`.
- R2: One cycle after a cycle with `in_vld` high, `v_out` equals `(a_in − b_in·w_in) mod Q`, taken as a non-negative residue.
- R3: `u_out` and `v_out` always lie in `0..Q−1` when the inputs are reduced residues.
- R4: `out_vld` equals the value `in_vld` had in the previous cycle.
- R5: After a cycle with `in_vld` low, `u_out` and `v_out` keep their values, whatever `a_in`, `b_in` and `w_in` carry.
- R6: While `rst` is high at a clock edge, `u_out`, `v_out` and `out_vld` are cleared to 0.
- R7: When `a + p` equals `Q` exactly, `u` wraps to 0. The largest raw sum, `2Q−2`, gives `Q−2`.
- R8: When `a` equals `p`, `v` is 0. When `a = 0` and `p = Q−1`, `v` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid this cycle |
| a_in | input | W | Residue a, below Q |
| b_in | input | W | Residue b, below Q |
| w_in | input | W | Twiddle residue, below Q |
| out_vld | output | 1 | Results valid |
| u_out | output | W | Registered (a + b·w) mod Q |
| v_out | output | W | Registered (a − b·w) mod Q |

W is the ceiling of log2(Q): 5 for the default `Q = 17`.

## Verification
The adder's downward correction and the subtractor's upward correction can both fire on the same operand set. This happens when `a + p ≥ Q` and `a < p` at once, for example `a = 5` with `p = 15`. The bench reaches this case through an exhaustive sweep of all 17³ operand triples and through directed cases. It judges both outputs in the same result cycle against a reference computed with plain integer `%`. So a wrong interaction between the two correction paths shows up as a mismatch on `u` or on `v`.

// File: rtl/zq_pkg.sv
package zq_pkg;
  // Default prime modulus of the residue field
  localparam int unsigned ZQ_MOD_DEF = 17;

  // Bits needed to hold a residue 0..q-1
  function automatic int unsigned zq_width(input int unsigned q);
    return $clog2(q);
  endfunction
endpackage

// File: rtl/zq_mod_mul.sv
module zq_mod_mul #(
  parameter int unsigned Q = zq_pkg::ZQ_MOD_DEF,
  parameter int unsigned W = zq_pkg::zq_width(Q)
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] prod
);
  localparam int unsigned PW = 2 * W;
  localparam logic [PW-1:0] QP = PW'(Q);

  logic [PW-1:0] full;
  logic [PW-1:0] rem;

  // full integer product, then one reduction
  always_comb begin
    full = PW'(x) * PW'(y);
    rem  = full % QP;
    prod = rem[W-1:0];
  end
endmodule

// File: rtl/zq_mod_add.sv
module zq_mod_add #(
  parameter int unsigned Q = zq_pkg::ZQ_MOD_DEF,
  parameter int unsigned W = zq_pkg::zq_width(Q)
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  localparam logic [W:0] QX = (W+1)'(Q);

  logic [W:0] raw;

  // one conditional subtraction of q
  always_comb begin
    raw = {1'b0, x} + {1'b0, y};
    if (raw >= QX) raw = raw - QX;
    sum = raw[W-1:0];
  end
endmodule

// File: rtl/zq_mod_sub.sv
module zq_mod_sub #(
  parameter int unsigned Q = zq_pkg::ZQ_MOD_DEF,
  parameter int unsigned W = zq_pkg::zq_width(Q)
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] diff
);
  localparam logic [W:0] QX = (W+1)'(Q);

  logic [W:0] raw;

  // borrow bit marks a negative difference; add q once
  always_comb begin
    raw = {1'b0, x} - {1'b0, y};
    if (raw[W]) raw = raw + QX;
    diff = raw[W-1:0];
  end
endmodule

// File: rtl/zq_butterfly.sv
module zq_butterfly #(
  parameter int unsigned Q = zq_pkg::ZQ_MOD_DEF,
  parameter int unsigned W = zq_pkg::zq_width(Q)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] w_in,
  output logic         out_vld,
  output logic [W-1:0] u_out,
  output logic [W-1:0] v_out
);
  logic [W-1:0] prod_bw;
  logic [W-1:0] u_nxt;
  logic [W-1:0] v_nxt;

  // single shared product feeds both paths
  zq_mod_mul #(.Q(Q), .W(W)) u_mul (.x(b_in), .y(w_in), .prod(prod_bw));
  zq_mod_add #(.Q(Q), .W(W)) u_add (.x(a_in), .y(prod_bw), .sum(u_nxt));
  zq_mod_sub #(.Q(Q), .W(W)) u_sub (.x(a_in), .y(prod_bw), .diff(v_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      u_out   <= '0;
      v_out   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        u_out <= u_nxt;
        v_out <= v_nxt;
      end
    end
  end

  // R3
  res_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(u_out) < Q) && (32'(v_out) < Q));

  // R4
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  // R4
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(u_out) && $stable(v_out)));

  // R1 R2: u + v is congruent to 2a
  sum_pair_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ((32'(u_out) + 32'(v_out)) % Q == (2 * 32'($past(a_in))) % Q));
endmodule

// File: tb/test_zq_butterfly.sv
module test_zq_butterfly;
  localparam int Q = 17;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, w_in = '0;
  logic         out_vld;
  logic [W-1:0] u_out, v_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  zq_butterfly #(.Q(Q), .W(W)) i_zq_butterfly (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .a_in(a_in), .b_in(b_in), .w_in(w_in),
    .out_vld(out_vld), .u_out(u_out), .v_out(v_out)
  );

  function automatic int ref_u(int a, int b, int w);
    return (a + b * w) % Q;
  endfunction

  function automatic int ref_v(int a, int b, int w);
    return ((a - (b * w) % Q) + Q) % Q;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one operand set, check results one edge later
  task automatic run_op(int a, int b, int w, string tag);
    @(negedge clk);
    in_vld = 1'b1;
    a_in = W'(a); b_in = W'(b); w_in = W'(w);
    @(negedge clk);
    in_vld = 1'b0;
    check({tag, " R1 u"}, int'(u_out), ref_u(a, b, w));
    check({tag, " R2 v"}, int'(v_out), ref_v(a, b, w));
    check({tag, " R3 range"}, int'(u_out < Q && v_out < Q), 1);
    check({tag, " R4 vld"}, int'(out_vld), 1);
  endtask

  initial begin
    int ru, rv;
    void'($urandom(32'd20240611));
    // R6 reset state
    repeat (3) @(negedge clk);
    check("R6 vld", int'(out_vld), 0);
    check("R6 u", int'(u_out), 0);
    check("R6 v", int'(v_out), 0);
    rst = 1'b0;

    // R7 sum boundaries: a+p == q and max raw sum
    run_op(16, 1, 1, "R7 exact");
    check("R7 wrap0", int'(u_out), 0);
    run_op(16, 4, 8, "R7 max");   // p = 32 mod 17 = 15 -> no; use a=16,p=16
    run_op(16, 4, 4, "R7 max16"); // p = 16, sum 32 -> 15
    check("R7 top", int'(u_out), 15);
    // R8 difference boundaries
    run_op(9, 3, 3, "R8 equal");  // p = 9
    check("R8 zero", int'(v_out), 0);
    run_op(0, 4, 4, "R8 neg");    // p = 16
    check("R8 one", int'(v_out), 1);
    // both corrections in one op: a=5, p=15
    run_op(5, 3, 5, "R7 R8 both");

    // R5 idle cycles ignore operand changes
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      ru = int'(u_out); rv = int'(v_out);
      in_vld = 1'b0;
      a_in = W'($urandom % Q); b_in = W'($urandom % Q); w_in = W'($urandom % Q);
      @(negedge clk);
      check("R5 u hold", int'(u_out), ru);
      check("R5 v hold", int'(v_out), rv);
      check("R4 idle vld", int'(out_vld), 0);
    end

    // exhaustive sweep of all triples
    for (int a = 0; a < Q; a++)
      for (int b = 0; b < Q; b++)
        for (int w = 0; w < Q; w++)
          run_op(a, b, w, "sweep");

    // random back-to-back stream with gaps
    for (int k = 0; k < 2000; k++) begin
      int a, b, w;
      a = int'($urandom % Q); b = int'($urandom % Q); w = int'($urandom % Q);
      run_op(a, b, w, "rand");
    end

    // R6 reset mid-run
    run_op(7, 7, 7, "pre-rst");
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b1;
    @(negedge clk);
    check("R6 mid vld", int'(out_vld), 0);
    check("R6 mid u", int'(u_out), 0);
    check("R6 mid v", int'(v_out), 0);
    rst = 1'b0; in_vld = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule